// File: doc/BRIEF.md
# Internal Control Register Bank

This block holds the 64-bit internal control registers of a processor core. Privileged move-to and move-from operations reach them through an index. Each register applies its own policy when written. Some keep only selected bits. Some clear themselves whatever value is written. Some can never be written, and some can never be read. Three of them store little or nothing: a write to one of these fires an action strobe toward the translation buffer, which lives outside this block. One register is a cycle-count view. Its upper half is the stored value and its lower half is a free-running counter. An index that names no register raises an illegal-operation fault.

Read data, the fault flag and the three invalidate strobes are all registered. They appear one clock after the read or write strobe. The single-entry invalidate also carries the written address and the address-space number that is current at the time of the write.

Top module: `icr_bank`

## Requirements
- R1: After reset every register reads zero except three. Index 8, the handler base, holds the HANDLER_BASE parameter. Index 9, the control register, holds 0x6. Index 3, a scratch register, holds the CORE_ID parameter.
- R2: A read or write strobe in cycle n yields rdata_o and fault_o in cycle n+1. Scratch indices 0 to 3, index 8 and index 9 store all 64 written bits.
- R3: A read of index 10 returns bits 63:32 of the stored value and bits 31:0 of a live counter. The counter advances by one every clock from zero at reset.
- R4: A write to index 11, the exception address, stores the value with bit 1 forced to zero.
- R5: Indices 12 and 13 keep only bits 3:0 of a write. Indices 14 and 15, the mode registers, keep only bits 4 and 3 (mask 0x18).
- R6: Indices 22 and 23, the page-table bases, keep only bits 63:30. Index 24, the address-space number, keeps only bits 10:4.
- R7: A write of any value to index 16 or index 17 leaves that register at zero.
- R8: A write to a read-only index (18, 19, 20, 21) raises fault_o and leaves the register unchanged.
- R9: A read of a write-only index (25 to 30) raises fault_o and returns zero read data.
- R10: A write to index 28 pulses inv_all_o, and a write to index 29 pulses inv_proc_o. Each pulse lasts exactly one cycle, and at most one invalidate strobe is high at a time.
- R11: A write to index 30 pulses inv_one_o. At the same time it presents the written value on inv_addr_o and bits 10:4 of index 24 on inv_asn_o.
- R12: A read or write of any other index (4 to 7, 31 and above) raises fault_o. A faulting read returns zero, and a faulting write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_i | input | 6 | Register index |
| wdata_i | input | 64 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 64 | Registered read data |
| fault_o | output | 1 | Illegal-operation fault for the previous access |
| inv_all_o | output | 1 | Invalidate-all strobe |
| inv_proc_o | output | 1 | Invalidate-per-process strobe |
| inv_one_o | output | 1 | Single-entry invalidate strobe |
| inv_addr_o | output | 64 | Address for the single-entry invalidate |
| inv_asn_o | output | 7 | Address-space number for the single-entry invalidate |

## Verification
Every result of this block is due exactly one rising edge after the strobe that caused it. This holds for read data, the fault flag and each invalidate strobe together with its address and address-space number. The bench drives each strobe on a falling edge, drops it on the next falling edge and samples the outputs at that same moment, so the sample sits half a cycle after the edge that produced the result. An idle falling edge then confirms that each strobe has fallen again. For the live counter the bench counts rising edges between two reads of index 10 and expects the lower halves to differ by exactly that count.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int IDX_W = 6;
  localparam int DW    = 64;
  localparam int NREG  = 32;
  localparam int RW    = $clog2(NREG);
  localparam int ASN_W = 7;
  localparam int ASN_LSB = 4;

  localparam int IX_SCR0  = 0;
  localparam int IX_HBASE = 8;
  localparam int IX_CTRL  = 9;
  localparam int IX_CYC   = 10;
  localparam int IX_EXCA  = 11;
  localparam int IX_ASTRQ = 12;
  localparam int IX_ASTEN = 13;
  localparam int IX_IMODE = 14;
  localparam int IX_DMODE = 15;
  localparam int IX_XSUM  = 16;
  localparam int IX_XMSK  = 17;
  localparam int IX_INTNO = 18;
  localparam int IX_MMST  = 19;
  localparam int IX_PTTI  = 20;
  localparam int IX_PTTD  = 21;
  localparam int IX_PTBI  = 22;
  localparam int IX_PTBD  = 23;
  localparam int IX_ASN   = 24;
  localparam int IX_HWCLR = 25;
  localparam int IX_DFL   = 26;
  localparam int IX_IFL   = 27;
  localparam int IX_INVA  = 28;
  localparam int IX_INVP  = 29;
  localparam int IX_INV1  = 30;
  localparam int SCR_CORE = 3;

  typedef enum logic [1:0] {ACT_NONE, ACT_ALL, ACT_PROC, ACT_ONE} act_e;

  typedef struct packed {
    logic          known;
    logic          rd_ok;
    logic          wr_ok;
    logic [DW-1:0] mask;
    act_e          act;
  } attr_t;

  function automatic attr_t icr_attr(logic [IDX_W-1:0] idx);
    attr_t a;
    int n;
    n = int'(idx);
    a = '{known: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1, mask: '1, act: ACT_NONE};
    case (n)
      0, 1, 2, 3, IX_HBASE, IX_CTRL, IX_CYC: ;
      IX_EXCA:                   a.mask = ~64'h2;
      IX_ASTRQ, IX_ASTEN:        a.mask = 64'hF;
      IX_IMODE, IX_DMODE:        a.mask = 64'h18;
      IX_XSUM, IX_XMSK:          a.mask = '0;
      IX_INTNO, IX_MMST, IX_PTTI, IX_PTTD: a.wr_ok = 1'b0;
      IX_PTBI, IX_PTBD:          a.mask = 64'hFFFF_FFFF_C000_0000;
      IX_ASN:                    a.mask = 64'h7F0;
      IX_HWCLR, IX_DFL, IX_IFL:  a.rd_ok = 1'b0;
      IX_INVA: begin a.rd_ok = 1'b0; a.mask = '0; a.act = ACT_ALL;  end
      IX_INVP: begin a.rd_ok = 1'b0; a.mask = '0; a.act = ACT_PROC; end
      IX_INV1: begin a.rd_ok = 1'b0; a.act = ACT_ONE; end
      default: begin a.known = 1'b0; a.rd_ok = 1'b0; a.wr_ok = 1'b0; end
    endcase
    return a;
  endfunction
endpackage

// File: rtl/icr_cyc_ctr.sv
module icr_cyc_ctr #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_o == CW'($past(cnt_o) + 1'b1));
endmodule

// File: rtl/icr_decode.sv
module icr_decode
  import icr_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output attr_t            attr_o
);
  assign attr_o = icr_attr(idx_i);
endmodule

// File: rtl/icr_store.sv
module icr_store
  import icr_pkg::*;
#(
  parameter logic [DW-1:0] HBASE_RST = '0,
  parameter logic [DW-1:0] CORE_ID   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [RW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [RW-1:0]    rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [ASN_W-1:0] asn_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RV = (i == IX_HBASE) ? HBASE_RST :
                                   (i == IX_CTRL)  ? 64'h6 :
                                   (i == SCR_CORE) ? CORE_ID : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[i] <= RV;
      else if (wr_en_i && int'(wr_idx_i) == i)   regs_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];
  assign asn_o     = regs_q[IX_ASN][ASN_LSB +: ASN_W];

  a_r4_exca_bit1_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[IX_EXCA][1] == 1'b0);
  a_r5_ast_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[IX_ASTRQ][DW-1:4] == '0);
  a_r6_asn_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_q[IX_ASN] & ~64'h7F0) == '0);
  a_r7_sum_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && int'(wr_idx_i) == IX_XSUM |=> regs_q[IX_XSUM] == '0);
  a_r8_ro_not_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !(int'(wr_idx_i) inside {IX_INTNO, IX_MMST, IX_PTTI, IX_PTTD}));
endmodule

// File: rtl/icr_bank.sv
module icr_bank
  import icr_pkg::*;
#(
  parameter logic [63:0] HANDLER_BASE = 64'h0000_0000_0000_8000,
  parameter logic [63:0] CORE_ID      = 64'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  idx_i,
  input  logic [63:0] wdata_i,
  input  logic        rd_i,
  input  logic        wr_i,
  output logic [63:0] rdata_o,
  output logic        fault_o,
  output logic        inv_all_o,
  output logic        inv_proc_o,
  output logic        inv_one_o,
  output logic [63:0] inv_addr_o,
  output logic [6:0]  inv_asn_o
);
  localparam int CYC_W = DW / 2;

  attr_t            attr;
  logic             wr_go, rd_go, bad;
  logic [DW-1:0]    st_rd, rd_val;
  logic [ASN_W-1:0] cur_asn;
  logic [CYC_W-1:0] cyc;

  icr_decode u_dec (.idx_i(idx_i), .attr_o(attr));

  icr_cyc_ctr #(.CW(CYC_W)) u_cyc (.clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(cyc));

  assign wr_go = wr_i & attr.wr_ok;
  assign rd_go = rd_i & attr.rd_ok;
  assign bad   = (wr_i & ~attr.wr_ok) | (rd_i & ~attr.rd_ok);

  icr_store #(.HBASE_RST(HANDLER_BASE), .CORE_ID(CORE_ID)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_go),
    .wr_idx_i  (idx_i[RW-1:0]),
    .wr_data_i (wdata_i & attr.mask),
    .rd_idx_i  (idx_i[RW-1:0]),
    .rd_data_o (st_rd),
    .asn_o     (cur_asn)
  );

  // counter view: stored upper half, live lower half
  assign rd_val = (int'(idx_i) == IX_CYC) ? {st_rd[DW-1:CYC_W], cyc} : st_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      fault_o    <= 1'b0;
      inv_all_o  <= 1'b0;
      inv_proc_o <= 1'b0;
      inv_one_o  <= 1'b0;
      inv_addr_o <= '0;
      inv_asn_o  <= '0;
    end else begin
      if (rd_go)     rdata_o <= rd_val;
      else if (rd_i) rdata_o <= '0;
      fault_o    <= bad;
      inv_all_o  <= wr_go && attr.act == ACT_ALL;
      inv_proc_o <= wr_go && attr.act == ACT_PROC;
      inv_one_o  <= wr_go && attr.act == ACT_ONE;
      if (wr_go && attr.act == ACT_ONE) begin
        inv_addr_o <= wdata_i;
        inv_asn_o  <= cur_asn;
      end
    end
  end

  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inv_all_o, inv_proc_o, inv_one_o}));
  a_r10_pulse_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_o && !(wr_i && int'(idx_i) == IX_INVA) |=> !inv_all_o);
  a_r12_unknown_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !attr.known |=> fault_o && rdata_o == '0);
  a_r9_wo_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && int'(idx_i) == IX_DFL |=> fault_o);
endmodule

// File: tb/icr_bank_bench.sv
module icr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] HB  = 64'hFFFF_FC00_0000_4000;
  localparam logic [63:0] CID = 64'h5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] idx = '0;
  logic [63:0] wdata = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [63:0] rdata, inv_addr;
  logic fault, inv_all, inv_proc, inv_one;
  logic [6:0] inv_asn;

  int checks = 0, failures = 0;
  bit done = 0;
  int unsigned tcyc = 0;
  logic [63:0] mdl [32];
  bit have_cyc = 0;
  logic [31:0] last_low;
  int unsigned last_t;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcyc <= tcyc + 1;

  icr_bank #(.HANDLER_BASE(HB), .CORE_ID(CID)) u_icr_bank (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .rdata_o(rdata), .fault_o(fault), .inv_all_o(inv_all), .inv_proc_o(inv_proc),
    .inv_one_o(inv_one), .inv_addr_o(inv_addr), .inv_asn_o(inv_asn));

  // 0 unknown, 1 read/write, 2 read-only, 3 write-only
  function automatic int kind_of(int ix);
    if (ix <= 3 || (ix >= 8 && ix <= 17) || (ix >= 22 && ix <= 24)) return 1;
    if (ix >= 18 && ix <= 21) return 2;
    if (ix >= 25 && ix <= 30) return 3;
    return 0;
  endfunction

  function automatic logic [63:0] mask_of(int ix);
    case (ix)
      11:      return ~64'h2;
      12, 13:  return 64'hF;
      14, 15:  return 64'h18;
      16, 17, 28, 29: return 64'h0;
      22, 23:  return 64'hFFFF_FFFF_C000_0000;
      24:      return 64'h7F0;
      default: return '1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int ix, input logic [63:0] d, input string req);
    int k;
    logic [6:0] asn_exp;
    k = kind_of(ix);
    asn_exp = mdl[24][10:4];
    @(negedge clk); idx = 6'(ix); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk(fault == (k == 0 || k == 2), req, {63'b0, fault}, {63'b0, (k == 0 || k == 2)});
    chk(inv_all == (ix == 28) && inv_proc == (ix == 29) && inv_one == (ix == 30), req,
        {61'b0, inv_all, inv_proc, inv_one}, {61'b0, ix == 28, ix == 29, ix == 30});
    if (ix == 30) begin
      chk(inv_addr == d, "R11 addr", inv_addr, d);
      chk(inv_asn == asn_exp, "R11 asn", {57'b0, inv_asn}, {57'b0, asn_exp});
    end
    if (k == 1 || k == 3) mdl[ix] = d & mask_of(ix);
  endtask

  task automatic do_read(input int ix, input string req);
    int k;
    logic [63:0] e;
    k = kind_of(ix);
    @(negedge clk); idx = 6'(ix); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(fault == (k == 0 || k == 3), req, {63'b0, fault}, {63'b0, (k == 0 || k == 3)});
    if (k == 0 || k == 3) chk(rdata == '0, req, rdata, '0);
    else if (ix == 10) begin
      chk(rdata[63:32] == mdl[10][63:32], "R3 upper", rdata, mdl[10]);
      if (have_cyc) begin
        e = {32'b0, last_low + 32'(tcyc - last_t)};
        chk(rdata[31:0] == e[31:0], "R3 lower", {32'b0, rdata[31:0]}, e);
      end
      have_cyc = 1; last_low = rdata[31:0]; last_t = tcyc;
    end else chk(rdata == mdl[ix], req, rdata, mdl[ix]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1CB5));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[8] = HB; mdl[9] = 64'h6; mdl[3] = CID;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fault == 0 && rdata == 0 && !inv_all && !inv_proc && !inv_one, "R1 outputs", rdata, '0);
    do_read(8, "R1 hbase"); do_read(9, "R1 ctrl"); do_read(3, "R1 core");
    do_read(0, "R1 scr0"); do_read(11, "R1 exca"); do_read(24, "R1 asn");
    do_write(1, 64'hA5A5_0123_4567_89AB, "R2 wr"); do_read(1, "R2 rd");
    do_write(10, 64'hDEAD_BEEF_1234_5678, "R3 wr");
    do_read(10, "R3 a"); repeat (5) @(negedge clk); do_read(10, "R3 b"); do_read(10, "R3 c");
    do_write(11, '1, "R4 wr"); do_read(11, "R4 rd");
    do_write(12, '1, "R5 wr"); do_read(12, "R5 ast");
    do_write(14, '1, "R5 wr"); do_read(14, "R5 mode");
    do_write(22, '1, "R6 wr"); do_read(22, "R6 ptb");
    do_write(24, '1, "R6 wr"); do_read(24, "R6 asn");
    do_write(16, '1, "R7 wr"); do_read(16, "R7 sum");
    do_write(17, 64'h55, "R7 wr"); do_read(17, "R7 msk");
    do_write(18, '1, "R8 wr"); do_read(18, "R8 rd");
    do_write(21, '1, "R8 wr"); do_read(21, "R8 rd");
    do_read(26, "R9 rd"); do_read(30, "R9 rd");
    do_write(28, '1, "R10 all");
    @(negedge clk); chk(!inv_all && !fault, "R10 end", {63'b0, inv_all}, '0);
    do_write(29, 64'h7, "R10 proc");
    @(negedge clk); chk(!inv_proc, "R10 end", {63'b0, inv_proc}, '0);
    do_write(24, 64'h350, "R11 asn");
    do_write(30, 64'h0000_1234_5678_A000, "R11 one");
    @(negedge clk); chk(!inv_one, "R11 end", {63'b0, inv_one}, '0);
    do_write(40, '1, "R12 wr"); do_read(40, "R12 rd");
    do_write(5, '1, "R12 wr"); do_read(5, "R12 rd");
    do_read(31, "R12 rd"); do_read(63, "R12 rd");
    for (int n = 0; n < 600; n++) begin
      int ix;
      ix = $urandom_range(0, 40);
      if ($urandom_range(0, 1) == 1) do_write(ix, {$urandom, $urandom}, "R2 rnd wr");
      else                           do_read(ix, "R2 rnd rd");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule